// File: doc/BRIEF.md
# Steerable Timer and Watchdog Prescaler

This block holds one 8-stage event prescaler and two counters: an 8-bit timer and a watchdog counter. A small control register steers the prescaler to one counter at a time. The owning counter advances once per divided tick. The other counter advances once per event from its own source, with no division. The timer's events come either from an internal instruction tick or from rising edges of an external pin, which is synchronized first. The watchdog's events come from its own tick input.

The control register also holds a 3-bit ratio code. A given code divides twice as hard when the prescaler serves the timer as when it serves the watchdog. Writing a new code or a new owner empties the prescaler, so the first tick under the new setting comes only after a full period. Each counter pulses a one-cycle timeout flag when it wraps to zero.

Top module: `steered_prescaler`

## Requirements
- R1: After reset, ctrl_rdata, tmr_count and wdt_count are 0, no timeout pulse is present, and the prescaler serves the timer at code 0 from the internal tick.
- R2: A write stores bits 0-2 (ratio code), bit 3 (owner: 0 timer, 1 watchdog) and bit 5 (timer source: 0 internal tick, 1 external pin). Bits 4, 6 and 7 always read as 0. ctrl_rdata holds its value when no write occurs.
- R3: With owner 0 and code c, the timer advances once every 2^(c+1) timer events, giving ratios 1:2 to 1:256.
- R4: With owner 1 and code c, the watchdog advances once every 2^c wdt_src events, giving ratios 1:1 to 1:128.
- R5: The counter that does not own the prescaler advances on every event of its own source.
- R6: With source bit 0 the timer event is ins_tick. With source bit 1 it is a rising edge of ext_pin, after a two-flop synchronizer. A level that is first sampled at clock edge k becomes an event that is counted at edge k+2.
- R7: A write that changes bits 0-3 clears the prescaler count and drops any tick in that cycle. The first divided tick after it needs a full ratio of events.
- R8: When the timer wraps from 0xFF to 0x00, tmr_timeout is high for exactly the one cycle in which tmr_count reads 0x00.
- R9: The watchdog counter is WDT_W bits wide, counts up by one, and pulses wdt_timeout for one cycle as it wraps to zero.
- R10: A control write takes effect from the next cycle. Events in the cycle of the write are handled under the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rdata | output | 8 | Control register readback |
| ins_tick | input | 1 | Internal instruction tick, one event per high cycle |
| ext_pin | input | 1 | Asynchronous external timer source |
| wdt_src | input | 1 | Watchdog event tick |
| tmr_tick | output | 1 | Timer advance strobe (divided or not, per owner) |
| wdt_tick | output | 1 | Watchdog advance strobe (divided or not, per owner) |
| tmr_count | output | 8 | Timer count |
| tmr_timeout | output | 1 | One-cycle pulse on timer wrap |
| wdt_count | output | WDT_W | Watchdog count |
| wdt_timeout | output | 1 | One-cycle pulse on watchdog wrap |

## Verification
A corrupted prescaler count or a wrong ratio mask shows up at once as a wrong tmr_count or wdt_count. It appears at the first divided tick that lands off its expected cycle, at most one full ratio period later. A stale count that survives a ratio change shows up as an early first tick after the write. A slip in the synchronizer depth moves every external-source increment by one cycle. Each of these is caught by the per-cycle comparison of the counts, the timeout flags and the readback against a reference model.

// File: rtl/steered_psc_pkg.sv
package steered_psc_pkg;
  localparam int CTRL_W       = 8;
  localparam int CTRL_SEL_LSB = 0;
  localparam int CTRL_OWN_BIT = 3;
  localparam int CTRL_SRC_BIT = 5;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 8'h2F;
  localparam logic [CTRL_W-1:0] CTRL_STEER = 8'h0F;
endpackage

// File: rtl/psc_edge_sync.sv
module psc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/psc_core.sv
module psc_core #(
  parameter int PSC_W = 8,
  localparam int SH_W = $clog2(PSC_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev,
  input  logic            clr,
  input  logic [SH_W-1:0] shift,
  output logic            tick
);
  logic [PSC_W-1:0] cnt_q, cnt_d, mask;
  logic [PSC_W:0]   full, mask_w;
  logic             cnt_en;

  always_comb begin
    full   = {{PSC_W{1'b0}}, 1'b1} << shift;
    mask_w = full - {{PSC_W{1'b0}}, 1'b1};
    mask   = mask_w[PSC_W-1:0];
    tick   = ev && !clr && ((cnt_q & mask) == mask);
    cnt_en = clr || ev;
    cnt_d  = clr ? '0 : cnt_q + {{(PSC_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/psc_wrap_ctr.sv
module psc_wrap_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap_q, wrap_d;

  always_comb begin
    cnt_d  = cnt_q + {{(W-1){1'b0}}, 1'b1};
    wrap_d = inc && (cnt_q == {W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= wrap_d;
      if (inc) cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
  assign wrap  = wrap_q;
endmodule

// File: rtl/steered_prescaler.sv
module steered_prescaler #(
  parameter int PSC_W       = 8,
  parameter int SEL_W       = 3,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wdata,
  output logic [7:0]       ctrl_rdata,
  input  logic             ins_tick,
  input  logic             ext_pin,
  input  logic             wdt_src,
  output logic             tmr_tick,
  output logic             wdt_tick,
  output logic [7:0]       tmr_count,
  output logic             tmr_timeout,
  output logic [WDT_W-1:0] wdt_count,
  output logic             wdt_timeout
);
  import steered_psc_pkg::*;

  localparam int SH_W = $clog2(PSC_W + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              own_wdt, src_ext, psc_clr, ext_rise, tmr_ev, psc_ev, psc_tick;
  logic [SEL_W-1:0]  code;
  logic [SH_W-1:0]   shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    ctrl_d  = ctrl_we ? (ctrl_wdata & CTRL_KEEP) : ctrl_q;
    psc_clr = ctrl_we && (((ctrl_wdata ^ ctrl_q) & CTRL_STEER) != '0);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ctrl_q <= '0;
    else            ctrl_q <= ctrl_d;
  end

  assign ctrl_rdata = ctrl_q;
  assign own_wdt    = ctrl_q[CTRL_OWN_BIT];
  assign src_ext    = ctrl_q[CTRL_SRC_BIT];
  assign code       = ctrl_q[CTRL_SEL_LSB +: SEL_W];

  psc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .pin(ext_pin), .rise(ext_rise)
  );

  always_comb begin
    tmr_ev = src_ext ? ext_rise : ins_tick;
    psc_ev = own_wdt ? wdt_src : tmr_ev;
    shift  = SH_W'(code) + (own_wdt ? SH_W'(0) : SH_W'(1));
  end

  psc_core #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_int_n), .ev(psc_ev), .clr(psc_clr),
    .shift(shift), .tick(psc_tick)
  );

  assign tmr_tick = own_wdt ? tmr_ev   : psc_tick;
  assign wdt_tick = own_wdt ? psc_tick : wdt_src;

  psc_wrap_ctr #(.W(8)) u_tmr (
    .clk(clk), .rst_n(rst_int_n), .inc(tmr_tick),
    .count(tmr_count), .wrap(tmr_timeout)
  );

  psc_wrap_ctr #(.W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_int_n), .inc(wdt_tick),
    .count(wdt_count), .wrap(wdt_timeout)
  );
endmodule

// File: rtl/steered_prescaler_chk.sv
module steered_prescaler_chk #(
  parameter int WDT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_we,
  input logic [7:0]       ctrl_rdata,
  input logic             ins_tick,
  input logic             wdt_src,
  input logic             tmr_tick,
  input logic             wdt_tick,
  input logic [7:0]       tmr_count,
  input logic             tmr_timeout,
  input logic [WDT_W-1:0] wdt_count,
  input logic             wdt_timeout
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_we) |-> $stable(ctrl_rdata));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_count != $past(tmr_count)) |-> (tmr_count == $past(tmr_count) + 8'd1));

  p_unity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[3] && ctrl_rdata[2:0] == 3'd0 && !ctrl_we) |-> (wdt_tick == wdt_src));

  p_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[3] && !ctrl_rdata[5]) |-> (tmr_tick == ins_tick));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_timeout |-> (tmr_count == 8'd0 && $past(tmr_count) == 8'hFF));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_timeout |=> !tmr_timeout);

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |-> (wdt_count == '0 && $past(wdt_count) == {WDT_W{1'b1}}));
endmodule

bind steered_prescaler steered_prescaler_chk #(.WDT_W(WDT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_rdata(ctrl_rdata),
  .ins_tick(ins_tick), .wdt_src(wdt_src), .tmr_tick(tmr_tick),
  .wdt_tick(wdt_tick), .tmr_count(tmr_count), .tmr_timeout(tmr_timeout),
  .wdt_count(wdt_count), .wdt_timeout(wdt_timeout)
);

// File: tb/tb_steered_prescaler.sv
module tb_steered_prescaler;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_we;
  logic [7:0] ctrl_wdata, ctrl_rdata;
  logic       ins_tick, ext_pin, wdt_src, tmr_tick, wdt_tick;
  logic [7:0] tmr_count, wdt_count;
  logic       tmr_timeout, wdt_timeout;

  always #2.5 clk = ~clk;

  steered_prescaler dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .ins_tick(ins_tick), .ext_pin(ext_pin),
    .wdt_src(wdt_src), .tmr_tick(tmr_tick), .wdt_tick(wdt_tick),
    .tmr_count(tmr_count), .tmr_timeout(tmr_timeout),
    .wdt_count(wdt_count), .wdt_timeout(wdt_timeout)
  );

  typedef struct {
    logic [7:0] tc; logic tto; logic [7:0] wc; logic wto; logic [7:0] rd;
    string req;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  logic [7:0] m_ctrl = 0, m_pc = 0, m_tc = 0, m_wc = 0;
  logic       m_s1 = 0, m_s2 = 0, m_s3 = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [7:0] wd, input bit ins,
                      input bit ext, input bit ws, input string req);
    logic rise, tev, pev, clr, ptick, tinc, winc, own;
    logic [3:0] k;
    logic [8:0] full;
    logic [7:0] mask;
    exp_t e;
    @(negedge clk);
    ctrl_we = we; ctrl_wdata = wd; ins_tick = ins; ext_pin = ext; wdt_src = ws;
    own   = m_ctrl[3];
    rise  = m_s2 & ~m_s3;
    tev   = m_ctrl[5] ? rise : ins;
    pev   = own ? ws : tev;
    k     = own ? {1'b0, m_ctrl[2:0]} : {1'b0, m_ctrl[2:0]} + 4'd1;
    full  = 9'd1 << k;
    mask  = 8'(full - 9'd1);
    clr   = we && (wd[3:0] != m_ctrl[3:0]);
    ptick = pev && !clr && ((m_pc & mask) == mask);
    tinc  = own ? tev : ptick;
    winc  = own ? ptick : ws;
    e.tto = tinc && (m_tc == 8'hFF);
    e.wto = winc && (m_wc == 8'hFF);
    m_tc  = m_tc + 8'(tinc);
    m_wc  = m_wc + 8'(winc);
    m_pc  = clr ? 8'd0 : (pev ? m_pc + 8'd1 : m_pc);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext;
    if (we) m_ctrl = wd & 8'h2F;
    e.tc = m_tc; e.wc = m_wc; e.rd = m_ctrl; e.req = req;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(tmr_count == e.tc, e.req, "tmr_count", tmr_count, e.tc);
      chk(tmr_timeout == e.tto, e.req, "tmr_timeout", tmr_timeout, e.tto);
      chk(wdt_count == e.wc, e.req, "wdt_count", wdt_count, e.wc);
      chk(wdt_timeout == e.wto, e.req, "wdt_timeout", wdt_timeout, e.wto);
      chk(ctrl_rdata == e.rd, e.req, "ctrl_rdata", ctrl_rdata, e.rd);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; ctrl_we = 0; ctrl_wdata = 0; ins_tick = 0; ext_pin = 0; wdt_src = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(ctrl_rdata == 8'h00, "R1", "ctrl_rdata", ctrl_rdata, 0);
    chk(tmr_count == 8'h00, "R1", "tmr_count", tmr_count, 0);
    chk(wdt_count == 8'h00, "R1", "wdt_count", wdt_count, 0);
    chk(!tmr_timeout && !wdt_timeout, "R1", "timeouts", {tmr_timeout, wdt_timeout}, 0);

    // R3 R8: timer 1:2 from reset code, every cycle an event, run past wrap
    for (int i = 0; i < 530; i++) step(0, 0, 1, 0, 0, "R3_R8_div2_wrap");
    // R3: sparse events at 1:2
    for (int i = 0; i < 40; i++) step(0, 0, (i % 3) == 0, 0, 0, "R3_sparse");

    // R2: readback with undefined bits set; code 7 to timer -> 1:256
    step(1, 8'hD7, 0, 0, 0, "R2_R10_write");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R2_hold");
    for (int i = 0; i < 600; i++) step(0, 0, 1, 0, 1, "R3_div256_R5_wdt_free");

    // R7: change to code 1 mid-count, events during write cycle
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, "R7_pre");
    step(1, 8'h01, 1, 0, 0, "R7_R10_change");
    for (int i = 0; i < 20; i++) step(0, 0, 1, 0, 0, "R7_after_clear");
    // R7: rewrite same setting does not clear
    step(0, 0, 1, 0, 0, "R7_pre_same");
    step(1, 8'h01, 1, 0, 0, "R7_same_write");
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 0, "R7_same_after");

    // R4 R5: owner watchdog, code 0 -> 1:1, timer free on ins_tick
    step(1, 8'h08, 1, 0, 1, "R4_R10_own_wdt");
    for (int i = 0; i < 300; i++) step(0, 0, (i % 2) == 0, 0, 1, "R4_div1_R5_R9_wrap");
    step(1, 8'h0B, 0, 0, 1, "R4_code3");
    for (int i = 0; i < 100; i++) step(0, 0, 1, 0, (i % 4) != 1, "R4_div8");
    step(1, 8'h0F, 0, 0, 0, "R4_code7");
    for (int i = 0; i < 300; i++) step(0, 0, 0, 0, 1, "R4_div128");

    // R6: external source, owner watchdog so timer counts every rise
    step(1, 8'h28, 0, 0, 0, "R6_ext_own_wdt");
    for (int i = 0; i < 60; i++) step(0, 0, 1, (i % 4) < 2, 0, "R6_ext_toggle");
    for (int i = 0; i < 20; i++) step(0, 0, 1, 1, 0, "R6_ext_held");
    // R6 R3: external source through 1:4 prescaler
    step(1, 8'h21, 0, 0, 0, "R6_ext_div4");
    for (int i = 0; i < 80; i++) step(0, 0, 0, (i % 2) == 0, 0, "R6_R3_ext_fast");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule